// File: doc/BRIEF.md
# Shadow-Gated Commit Controller

This block decides when each computation unit in an out-of-order core may write its result back. An instruction that still depends on an unresolved earlier event is issued under one or more speculation shadows. Examples of such events are a pending branch or a load or store to a device whose accesses have side effects. A shadowed unit may finish computing, but it may not ask for the write port until every shadow it holds has resolved as a success. If any of its shadows is cancelled, the unit is dropped back to idle without ever writing.

Shadows do not hold back issue themselves. A unit stays busy from the cycle it accepts an instruction until its result is written or cancelled. Issue stalls only when every unit of the requested kind is busy. A single write port is shared: a picker grants go-write to one requesting unit per cycle, in round-robin order by default.

Top module: `shadow_commit_ctrl`

## Requirements
- R1: After reset, `busy`, `release_req` and `go_write` are all zero, and `issue_stall` is zero while `issue_valid` is low.
- R2: Unit i is of kind (i mod NUM_TYPES). With the defaults, even units are kind 0 and odd units are kind 1. When `issue_valid` is high, `issue_grant` is one-hot on the lowest-index idle unit of kind `issue_type` in the same cycle, and that unit reads busy from the next cycle.
- R3: `issue_stall` is high in the same cycle exactly when `issue_valid` is high and every unit of the requested kind is busy. During a stall `issue_grant` is zero and no unit becomes busy. Shadows held by busy units never cause a stall by themselves.
- R4: A `done` pulse in cycle t, on a busy unit holding no shadow, raises that unit's `release_req` from cycle t+1. When the picker selects the unit, `go_write` rises in that same cycle.
- R5: A unit holding any shadow bit never raises `release_req`, even after its `done` has been seen. Its shadow set is taken from `issue_mask` at issue, with bit s meaning shadow source s.
- R6: A pulse on `shadow_ok[s]` clears shadow s in every unit, including a unit that is being issued in the same cycle. A finished unit left with no shadows then requests release on the next cycle.
- R7: A pulse on `shadow_kill[s]` makes every busy unit that holds shadow s idle on the next cycle, with no `go_write` for it. An issue in the same cycle whose mask contains s is accepted on `issue_grant`, but the unit stays idle.
- R8: At most one `go_write` bit is high in any cycle, and only for a unit whose `release_req` is high.
- R9: A unit given `go_write` in cycle t reads not busy in cycle t+1.
- R10: In round-robin mode, after a grant to unit g the search starts at unit g+1 and wraps around. In fixed mode the lowest index always wins.
- R11: A `done` pulse on an idle unit has no effect: the unit neither requests release then nor after a later issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction is offered for issue |
| issue_type | input | TYPE_W | Unit kind the instruction needs |
| issue_mask | input | NUM_SHADOWS | Shadows the instruction is placed under |
| issue_grant | output | NUM_UNITS | One-hot unit accepting the instruction |
| issue_stall | output | 1 | No idle unit of the requested kind |
| shadow_ok | input | NUM_SHADOWS | Per-shadow success pulse |
| shadow_kill | input | NUM_SHADOWS | Per-shadow cancel pulse |
| done | input | NUM_UNITS | Per-unit computation finished pulse |
| release_req | output | NUM_UNITS | Unit asks for the write port |
| go_write | output | NUM_UNITS | Write port granted, one-hot or zero |
| busy | output | NUM_UNITS | Unit is holding an instruction |

## Verification
A unit with a stale shadow bit shows up at the ports as a `release_req` that never rises after `done`. If the bit was wrongly cleared instead, the request appears one cycle after `done` despite the outstanding shadow. A wrong busy flag shows up in the same cycle as a wrong `issue_grant` or `issue_stall`, or one cycle after a write or cancel as a busy bit that does not drop. A wrong round-robin pointer shows up only when two units request together, as the wrong `go_write` bit in that cycle. The directed tests arrange such simultaneous requests on purpose.

// File: rtl/scc_pkg.sv
package scc_pkg;

    typedef enum logic {
        PICK_FIXED       = 1'b0,
        PICK_ROUND_ROBIN = 1'b1
    } pick_mode_e;

    // Kind of a unit as a function of its index.
    function automatic int unsigned unit_kind(int unsigned idx, int unsigned kinds);
        return idx % kinds;
    endfunction

    // Width needed to encode a kind number (at least one bit).
    function automatic int unsigned kind_width(int unsigned kinds);
        return (kinds > 1) ? $clog2(kinds) : 1;
    endfunction

endpackage

// File: rtl/scc_unit_slot.sv
module scc_unit_slot #(
    parameter int NUM_SHADOWS = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [NUM_SHADOWS-1:0] load_mask,
    input  logic [NUM_SHADOWS-1:0] shadow_ok,
    input  logic [NUM_SHADOWS-1:0] shadow_kill,
    input  logic                   done_in,
    input  logic                   write_grant,
    output logic                   busy,
    output logic                   release_req,
    output logic [NUM_SHADOWS-1:0] shadow_q
);

    typedef struct packed {
        logic                   busy;
        logic                   done;
        logic [NUM_SHADOWS-1:0] shadow;
    } slot_t;

    slot_t state_q, state_d;
    logic  load_squashed;
    logic  held_killed;

    assign load_squashed = |(load_mask & shadow_kill);
    assign held_killed   = |(state_q.shadow & shadow_kill);

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d.busy   = !load_squashed;
            state_d.done   = 1'b0;
            state_d.shadow = load_squashed ? '0 : (load_mask & ~shadow_ok);
        end else if (state_q.busy) begin
            if (write_grant || held_killed) begin
                state_d = '0;
            end else begin
                state_d.shadow = state_q.shadow & ~shadow_ok;
                state_d.done   = state_q.done | done_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy        = state_q.busy;
    assign shadow_q    = state_q.shadow;
    assign release_req = state_q.busy & state_q.done & ~|state_q.shadow;

endmodule

// File: rtl/scc_issue_select.sv
module scc_issue_select #(
    parameter int NUM_UNITS = 4,
    parameter int NUM_TYPES = 2,
    parameter int TYPE_W    = 1
) (
    input  logic                 issue_valid,
    input  logic [TYPE_W-1:0]    issue_type,
    input  logic [NUM_UNITS-1:0] busy,
    output logic [NUM_UNITS-1:0] grant,
    output logic                 stall
);

    logic [NUM_UNITS-1:0] kind_match;
    logic [NUM_UNITS-1:0] idle_match;

    for (genvar i = 0; i < NUM_UNITS; i++) begin : g_kind
        assign kind_match[i] =
            (issue_type == TYPE_W'(scc_pkg::unit_kind(i, NUM_TYPES)));
    end

    assign idle_match = kind_match & ~busy;
    assign grant      = issue_valid ? (idle_match & (~idle_match + NUM_UNITS'(1))) : '0;
    assign stall      = issue_valid & ~|idle_match;

endmodule

// File: rtl/scc_write_picker.sv
module scc_write_picker #(
    parameter int                NUM_UNITS = 4,
    parameter scc_pkg::pick_mode_e MODE    = scc_pkg::PICK_ROUND_ROBIN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_UNITS-1:0] req,
    output logic [NUM_UNITS-1:0] grant
);

    localparam int PTR_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

    if (MODE == scc_pkg::PICK_ROUND_ROBIN) begin : g_rr
        logic [PTR_W-1:0]     ptr_q;
        logic [PTR_W-1:0]     win_idx;
        logic [NUM_UNITS-1:0] at_or_above;
        logic [NUM_UNITS-1:0] upper;
        logic [NUM_UNITS-1:0] source;

        always_comb begin
            for (int i = 0; i < NUM_UNITS; i++) begin
                at_or_above[i] = (i >= int'(ptr_q));
            end
        end

        assign upper  = req & at_or_above;
        assign source = (|upper) ? upper : req;
        assign grant  = source & (~source + NUM_UNITS'(1));

        always_comb begin
            win_idx = '0;
            for (int i = 0; i < NUM_UNITS; i++) begin
                if (grant[i]) win_idx = PTR_W'(i);
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q <= '0;
            end else if (|grant) begin
                ptr_q <= (win_idx == PTR_W'(NUM_UNITS - 1)) ? '0 : win_idx + PTR_W'(1);
            end
        end
    end else begin : g_fixed
        assign grant = req & (~req + NUM_UNITS'(1));
    end

endmodule

// File: rtl/shadow_commit_ctrl.sv
module shadow_commit_ctrl #(
    parameter int                  NUM_UNITS   = 4,
    parameter int                  NUM_SHADOWS = 3,
    parameter int                  NUM_TYPES   = 2,
    parameter scc_pkg::pick_mode_e PICK_MODE   = scc_pkg::PICK_ROUND_ROBIN,
    localparam int                 TYPE_W      = scc_pkg::kind_width(NUM_TYPES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   issue_valid,
    input  logic [TYPE_W-1:0]      issue_type,
    input  logic [NUM_SHADOWS-1:0] issue_mask,
    output logic [NUM_UNITS-1:0]   issue_grant,
    output logic                   issue_stall,
    input  logic [NUM_SHADOWS-1:0] shadow_ok,
    input  logic [NUM_SHADOWS-1:0] shadow_kill,
    input  logic [NUM_UNITS-1:0]   done,
    output logic [NUM_UNITS-1:0]   release_req,
    output logic [NUM_UNITS-1:0]   go_write,
    output logic [NUM_UNITS-1:0]   busy
);

    localparam int SH_BITS = NUM_UNITS * NUM_SHADOWS;

    logic [SH_BITS-1:0] unit_shadow;

    scc_issue_select #(
        .NUM_UNITS (NUM_UNITS),
        .NUM_TYPES (NUM_TYPES),
        .TYPE_W    (TYPE_W)
    ) u_select (
        .issue_valid (issue_valid),
        .issue_type  (issue_type),
        .busy        (busy),
        .grant       (issue_grant),
        .stall       (issue_stall)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_slot
        scc_unit_slot #(
            .NUM_SHADOWS (NUM_SHADOWS)
        ) u_slot (
            .clk         (clk),
            .rst         (rst),
            .load        (issue_grant[u]),
            .load_mask   (issue_mask),
            .shadow_ok   (shadow_ok),
            .shadow_kill (shadow_kill),
            .done_in     (done[u]),
            .write_grant (go_write[u]),
            .busy        (busy[u]),
            .release_req (release_req[u]),
            .shadow_q    (unit_shadow[u*NUM_SHADOWS +: NUM_SHADOWS])
        );
    end

    scc_write_picker #(
        .NUM_UNITS (NUM_UNITS),
        .MODE      (PICK_MODE)
    ) u_picker (
        .clk   (clk),
        .rst   (rst),
        .req   (release_req),
        .grant (go_write)
    );

endmodule

// File: rtl/shadow_commit_ctrl_chk.sv
module shadow_commit_ctrl_chk #(
    parameter int N_UNITS   = 4,
    parameter int N_SHADOWS = 3
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           issue_valid,
    input logic                           issue_stall,
    input logic [N_SHADOWS-1:0]           shadow_kill,
    input logic [N_UNITS-1:0]             busy,
    input logic [N_UNITS-1:0]             release_req,
    input logic [N_UNITS-1:0]             go_write,
    input logic [N_UNITS*N_SHADOWS-1:0]   unit_shadow
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (busy == '0)); // R1

    AST_STALL_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (rst)
        issue_stall |-> issue_valid); // R3

    AST_STALL_NO_NEW_BUSY: assert property (@(posedge clk) disable iff (rst)
        issue_stall |=> ((busy & ~$past(busy)) == '0)); // R3

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(go_write)); // R8

    AST_WRITE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        ((go_write & ~release_req) == '0)); // R8

    AST_WRITE_FREES: assert property (@(posedge clk) disable iff (rst)
        (|go_write) |=> ((busy & $past(go_write)) == '0)); // R9

    AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        ((release_req & ~busy) == '0)); // R11

    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (|unit_shadow[i*N_SHADOWS +: N_SHADOWS]) |-> !release_req[i]); // R5

        AST_KILL_FREES: assert property (@(posedge clk) disable iff (rst)
            (busy[i] && |(unit_shadow[i*N_SHADOWS +: N_SHADOWS] & shadow_kill))
            |=> !busy[i]); // R7
    end

endmodule

bind shadow_commit_ctrl shadow_commit_ctrl_chk #(
    .N_UNITS   (NUM_UNITS),
    .N_SHADOWS (NUM_SHADOWS)
) chk (.*);

// File: tb/shadow_commit_ctrl_test.sv
module shadow_commit_ctrl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       issue_valid = 1'b0;
    logic [0:0] issue_type = '0;
    logic [2:0] issue_mask = '0;
    logic [3:0] issue_grant;
    logic       issue_stall;
    logic [2:0] shadow_ok = '0;
    logic [2:0] shadow_kill = '0;
    logic [3:0] done = '0;
    logic [3:0] release_req;
    logic [3:0] go_write;
    logic [3:0] busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    shadow_commit_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .issue_valid (issue_valid),
        .issue_type  (issue_type),
        .issue_mask  (issue_mask),
        .issue_grant (issue_grant),
        .issue_stall (issue_stall),
        .shadow_ok   (shadow_ok),
        .shadow_kill (shadow_kill),
        .done        (done),
        .release_req (release_req),
        .go_write    (go_write),
        .busy        (busy)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        done        = '0;
        shadow_ok   = '0;
        shadow_kill = '0;
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst = 1'b1;
        issue_valid = 1'b0;
        done = '0; shadow_ok = '0; shadow_kill = '0;
        repeat (2) tick();
        rst = 1'b0;
    endtask

    task automatic issue(logic [0:0] kind, logic [2:0] mask, logic [2:0] ok,
                         logic [2:0] kill, logic [3:0] exp_grant, logic exp_stall,
                         string tag);
        issue_valid = 1'b1;
        issue_type  = kind;
        issue_mask  = mask;
        shadow_ok   = ok;
        shadow_kill = kill;
        #1;
        check({tag, " grant"}, 32'(issue_grant), 32'(exp_grant));
        check({tag, " stall"}, 32'(issue_stall), 32'(exp_stall));
        tick();
        issue_valid = 1'b0;
        issue_mask  = '0;
    endtask

    task automatic test_reset();
        reset_dut();
        check("R1 busy", 32'(busy), 0);
        check("R1 release_req", 32'(release_req), 0);
        check("R1 go_write", 32'(go_write), 0);
        check("R1 stall", 32'(issue_stall), 0);
    endtask

    task automatic test_fill_and_commit();
        reset_dut();
        issue(0, 0, 0, 0, 4'b0001, 0, "R2 kind0 first");
        check("R2 busy u0", 32'(busy), 32'b0001);
        issue(1, 0, 0, 0, 4'b0010, 0, "R2 kind1 first");
        issue(0, 0, 0, 0, 4'b0100, 0, "R2 kind0 second");
        issue(0, 0, 0, 0, 4'b0000, 1, "R3 kind0 full");
        check("R3 busy unchanged", 32'(busy), 32'b0111);
        issue(1, 0, 0, 0, 4'b1000, 0, "R2 kind1 second");
        issue(1, 0, 0, 0, 4'b0000, 1, "R3 kind1 full");
        check("R2 all busy", 32'(busy), 32'b1111);
        done = 4'b0010;
        #1 check("R4 no early req", 32'(release_req), 0);
        tick();
        check("R4 req", 32'(release_req), 32'b0010);
        check("R4 go_write", 32'(go_write), 32'b0010);
        tick();
        check("R9 freed", 32'(busy), 32'b1101);
        check("R9 no repeat write", 32'(go_write), 0);
        done = 4'b0101;
        tick();
        check("R8 both req", 32'(release_req), 32'b0101);
        check("R10 rr picks u2", 32'(go_write), 32'b0100);
        tick();
        check("R10 wrap to u0", 32'(go_write), 32'b0001);
        check("R9 u2 freed", 32'(busy), 32'b1001);
        tick();
        check("R9 u0 freed", 32'(busy), 32'b1000);
        check("R8 idle port", 32'(go_write), 0);
        done = 4'b1000;
        tick();
        check("R4 u3 write", 32'(go_write), 32'b1000);
        tick();
        check("R9 all free", 32'(busy), 0);
    endtask

    task automatic test_shadow_hold();
        reset_dut();
        issue(0, 3'b001, 0, 0, 4'b0001, 0, "R5 shadowed issue");
        done = 4'b0001;
        tick();
        check("R5 no req", 32'(release_req), 0);
        check("R5 no write", 32'(go_write), 0);
        tick();
        check("R5 still no req", 32'(release_req), 0);
        check("R5 still busy", 32'(busy), 32'b0001);
        issue(0, 0, 0, 0, 4'b0100, 0, "R3 no stall from shadow");
        done = 4'b0100;
        tick();
        check("R5 other unit writes", 32'(go_write), 32'b0100);
        tick();
        check("R5 shadowed kept", 32'(busy), 32'b0001);
        shadow_ok = 3'b001;
        tick();
        check("R6 req after ok", 32'(release_req), 32'b0001);
        check("R6 write after ok", 32'(go_write), 32'b0001);
        tick();
        check("R6 freed", 32'(busy), 0);
    endtask

    task automatic test_kill();
        reset_dut();
        issue(0, 3'b010, 0, 0, 4'b0001, 0, "R7 issue u0");
        issue(0, 3'b001, 0, 0, 4'b0100, 0, "R7 issue u2");
        done = 4'b0101;
        tick();
        check("R5 both held", 32'(release_req), 0);
        shadow_kill = 3'b010;
        #1 check("R7 no write on kill", 32'(go_write), 0);
        tick();
        check("R7 killed unit free", 32'(busy), 32'b0100);
        check("R7 no write after", 32'(go_write), 0);
        shadow_ok = 3'b001;
        tick();
        check("R6 survivor writes", 32'(go_write), 32'b0100);
        tick();
        check("R6 survivor free", 32'(busy), 0);
        issue(1, 3'b100, 0, 3'b100, 4'b0010, 0, "R7 same-cycle kill");
        check("R7 issue dropped", 32'(busy), 0);
        issue(1, 3'b100, 3'b100, 0, 4'b0010, 0, "R6 same-cycle ok");
        check("R6 issued busy", 32'(busy), 32'b0010);
        done = 4'b0010;
        tick();
        check("R6 cleared at issue", 32'(go_write), 32'b0010);
        tick();
        check("R6 freed", 32'(busy), 0);
    endtask

    task automatic test_idle_done();
        reset_dut();
        done = 4'b1111;
        tick();
        check("R11 no req", 32'(release_req), 0);
        check("R11 no busy", 32'(busy), 0);
        check("R11 no write", 32'(go_write), 0);
        issue(0, 0, 0, 0, 4'b0001, 0, "R11 issue");
        tick();
        check("R11 stale done ignored", 32'(release_req), 0);
        check("R11 unit still busy", 32'(busy), 32'b0001);
    endtask

    initial begin
        test_reset();
        test_fill_and_commit();
        test_shadow_hold();
        test_kill();
        test_idle_done();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule